// File: doc/BRIEF.md
# Quad Cascadable 8-bit Event Counter

This block holds four 8-bit event counters, numbered 0 to 3, that a processor controls through static configuration inputs and a small register port. Each counter picks one of four tick sources, counts up or down when its enable bit is set, and runs as a plain counter or as a PWM counter. Every source arrives as a one-cycle enable pulse in the system clock domain. External pin edges are synchronized before they reach the block. Each counter also has a compare register. Writing that register changes the compare value. In counter mode the write also queues a change to the count, and that change is applied on the next enabled tick.

Counters 0 and 1 can be joined into one 16-bit counter, and so can counters 2 and 3. In a joined pair the lower counter's enable bit, direction, mode and tick drive the whole pair. The upper byte moves only when the lower byte wraps. The compare match and the PWM level then use the full 16-bit value and are reported on the lower counter's output bit.

Top module: `qcnt_unit`

## Requirements
- R1: After reset every count and compare value is 0, and `wr_pending`, `cmp_match` and `pwm_out` are all 0.
- R2: Counter i's source is selected by `ck_sel[2i+1:2i]`. Code 3 selects `pin_tick[i]`. Codes 0 to 2 select `int_tick[3*(i/2)+code]`. An enabled counter changes by one on each selected tick and ignores all other tick inputs.
- R3: While a counter's effective enable is 0, its count does not change, whatever ticks arrive.
- R4: A compare write to a counter that is not in PWM mode with up-counting does two things: it stores the compare value and sets `wr_pending`. On the next enabled tick the count becomes 0 instead of advancing, and the pending bit clears.
- R5: The same write with down-counting instead makes the next enabled tick load the compare value into the count, and the pending bit clears.
- R6: A compare write in PWM mode changes only the compare value. The count and the pending bit keep their values.
- R7: Changing a counter's mode bit leaves its count unchanged.
- R8: Up-counting wraps from 0xFF to 0x00. Down-counting wraps from 0x00 to 0xFF.
- R9: When `cascade[p]` is 1, counter 2p+1 ignores its own enable bit and its own tick. It advances only on a tick where counter 2p wraps.
- R10: `cmp_match[i]` is high for exactly one cycle: the cycle in which the count first shows a value reached by a count step that equals the compare value. Loads never raise it. In a joined pair the 16-bit value is compared on bit 2p, and bit 2p+1 stays 0.
- R11: `pwm_out[i]` is 1 exactly when the counter is in PWM mode and its count is below its compare value. In a joined pair this test uses 16 bits and is reported on bit 2p, and bit 2p+1 is 0.
- R12: `rd_data` always shows the current count of the counter selected by `rd_sel`.
- R13: In a joined pair, a counter-mode write to either byte marks both bytes pending. On the next enabled tick both bytes are cleared or loaded together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_on | input | 4 | Per-counter enable bits |
| ck_sel | input | 8 | Two-bit source select per counter |
| cnt_dn | input | 4 | 1 = count down |
| pwm_mode | input | 4 | 1 = PWM mode |
| cascade | input | 2 | Joins pair 0/1 (bit 0) and pair 2/3 (bit 1) |
| int_tick | input | 6 | Internal divided-clock tick pulses, three per pair |
| pin_tick | input | 4 | Synchronized external pin edge pulses |
| wr_en | input | 1 | Compare register write strobe |
| wr_sel | input | 2 | Counter addressed by the write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Counter shown on rd_data |
| rd_data | output | 8 | Selected counter's count |
| cmp_match | output | 4 | One-cycle compare match pulses |
| pwm_out | output | 4 | PWM level per counter |
| wr_pending | output | 4 | Deferred write not yet applied |

## Verification
A lost or stuck pending bit shows up on `wr_pending` right after the write. On the next selected tick it also shows up as a wrong count on `rd_data`: an increment where a clear or load was due, or the reverse. A wrong cascade carry shows up only after the lower byte reaches its wrap value, so the bench runs a joined pair through more than 256 ticks. A wrong compare value shows up as a missing or misplaced `cmp_match` pulse, and as an immediate change in the level of `pwm_out`.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;
    localparam int NCNT  = 4;
    localparam int NPAIR = NCNT / 2;
    localparam int NSRC  = 3;

    typedef struct packed {
        logic [NCNT-1:0] pend;
        logic [NCNT-1:0] match;
    } qcnt_state_t;
endpackage

// File: rtl/qcnt_tick_sel.sv
module qcnt_tick_sel #(
    parameter int NSRC = 3
) (
    input  logic [1:0]      sel,
    input  logic [NSRC-1:0] int_tick,
    input  logic            pin,
    output logic            tick
);
    always_comb begin
        case (sel)
            2'd0:    tick = int_tick[0];
            2'd1:    tick = int_tick[1];
            2'd2:    tick = int_tick[2];
            default: tick = pin;
        endcase
    end
endmodule

// File: rtl/qcnt_slice.sv
module qcnt_slice #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cmp,
    input  logic [CW-1:0] wr_data,
    input  logic          do_load,
    input  logic          load_cmp,
    input  logic          do_step,
    input  logic          step_dn,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cmp,
    output logic [CW-1:0] cnt_next,
    output logic          at_wrap
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] cmp;
    } slice_t;

    slice_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_cmp)
            st_d.cmp = wr_data;
        if (do_load)
            st_d.cnt = load_cmp ? st_q.cmp : '0;
        else if (do_step)
            st_d.cnt = step_dn ? st_q.cnt - 1'b1 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt      = st_q.cnt;
    assign cmp      = st_q.cmp;
    assign cnt_next = st_d.cnt;
    assign at_wrap  = step_dn ? (st_q.cnt == '0) : (st_q.cnt == '1);

    AST_LOAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        do_load && !load_cmp |=> cnt == '0); // R4
    AST_LOAD_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        do_load && load_cmp |=> cnt == $past(cmp)); // R5
endmodule

// File: rtl/qcnt_unit.sv
module qcnt_unit
    import qcnt_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCNT-1:0]      cnt_on,
    input  logic [2*NCNT-1:0]    ck_sel,
    input  logic [NCNT-1:0]      cnt_dn,
    input  logic [NCNT-1:0]      pwm_mode,
    input  logic [NPAIR-1:0]     cascade,
    input  logic [NPAIR*NSRC-1:0] int_tick,
    input  logic [NCNT-1:0]      pin_tick,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [CW-1:0]        wr_data,
    input  logic [1:0]           rd_sel,
    output logic [CW-1:0]        rd_data,
    output logic [NCNT-1:0]      cmp_match,
    output logic [NCNT-1:0]      pwm_out,
    output logic [NCNT-1:0]      wr_pending
);
    localparam int DW = 2 * CW;

    qcnt_state_t st_d, st_q;

    logic [NCNT-1:0] tk, en_eff, dn_eff, pwm_eff, go, load, step, wr_hit, wrap;
    logic [CW-1:0]   cnt [NCNT];
    logic [CW-1:0]   cmp [NCNT];
    logic [CW-1:0]   nxt [NCNT];

    // Source select and one 8-bit slice per counter
    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        qcnt_tick_sel #(.NSRC(NSRC)) u_sel (
            .sel      (ck_sel[2*i +: 2]),
            .int_tick (int_tick[NSRC*(i/2) +: NSRC]),
            .pin      (pin_tick[i]),
            .tick     (tk[i])
        );
        qcnt_slice #(.CW(CW)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_cmp   (wr_hit[i]),
            .wr_data  (wr_data),
            .do_load  (load[i]),
            .load_cmp (dn_eff[i]),
            .do_step  (step[i]),
            .step_dn  (dn_eff[i]),
            .cnt      (cnt[i]),
            .cmp      (cmp[i]),
            .cnt_next (nxt[i]),
            .at_wrap  (wrap[i])
        );
        assign wr_hit[i] = wr_en && (wr_sel == 2'(i));
    end

    // Pair control: cascade hands the upper slice to the lower one
    always_comb begin
        logic c, g_lo, pg_lo, pg_hi;
        en_eff = '0; dn_eff = '0; pwm_eff = '0;
        go = '0; load = '0; step = '0; pwm_out = '0;
        st_d = st_q;
        for (int p = 0; p < NPAIR; p++) begin
            c     = cascade[p];
            g_lo  = tk[2*p] & cnt_on[2*p];
            pg_lo = c ? (st_q.pend[2*p] | st_q.pend[2*p+1]) : st_q.pend[2*p];
            pg_hi = c ? pg_lo : st_q.pend[2*p+1];

            en_eff[2*p]    = cnt_on[2*p];
            en_eff[2*p+1]  = c ? cnt_on[2*p]   : cnt_on[2*p+1];
            dn_eff[2*p]    = cnt_dn[2*p];
            dn_eff[2*p+1]  = c ? cnt_dn[2*p]   : cnt_dn[2*p+1];
            pwm_eff[2*p]   = pwm_mode[2*p];
            pwm_eff[2*p+1] = c ? pwm_mode[2*p] : pwm_mode[2*p+1];

            go[2*p]     = g_lo;
            go[2*p+1]   = c ? g_lo : (tk[2*p+1] & cnt_on[2*p+1]);
            load[2*p]   = g_lo & pg_lo;
            load[2*p+1] = go[2*p+1] & pg_hi;
            step[2*p]   = g_lo & ~pg_lo;
            step[2*p+1] = c ? (g_lo & ~pg_lo & wrap[2*p])
                            : (go[2*p+1] & ~pg_hi);

            if (c) begin
                st_d.match[2*p]   = step[2*p] &&
                    ({nxt[2*p+1], nxt[2*p]} == {cmp[2*p+1], cmp[2*p]});
                st_d.match[2*p+1] = 1'b0;
                pwm_out[2*p]      = pwm_eff[2*p] &&
                    (DW'({cnt[2*p+1], cnt[2*p]}) < DW'({cmp[2*p+1], cmp[2*p]}));
            end else begin
                st_d.match[2*p]   = step[2*p]   && (nxt[2*p]   == cmp[2*p]);
                st_d.match[2*p+1] = step[2*p+1] && (nxt[2*p+1] == cmp[2*p+1]);
                pwm_out[2*p]      = pwm_eff[2*p]   && (cnt[2*p]   < cmp[2*p]);
                pwm_out[2*p+1]    = pwm_eff[2*p+1] && (cnt[2*p+1] < cmp[2*p+1]);
            end
        end
        for (int i = 0; i < NCNT; i++) begin
            if (wr_hit[i] && !pwm_eff[i])
                st_d.pend[i] = 1'b1;
            else if (load[i])
                st_d.pend[i] = 1'b0;
        end
        if (wr_en && !pwm_eff[wr_sel]) begin
            for (int p = 0; p < NPAIR; p++)
                if (cascade[p] && (wr_sel[1] == p[0]))
                    st_d.pend[2*p +: 2] = 2'b11; // R13 joined pair goes pending together
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data    = cnt[rd_sel];
    assign cmp_match  = st_q.match;
    assign wr_pending = st_q.pend;

    for (genvar i = 0; i < NCNT; i++) begin : g_chk
        AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            !en_eff[i] |=> $stable(cnt[i])); // R3
        AST_PEND_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(wr_pending[i]) |-> $past(wr_en)); // R4
        AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_match[i] |=> !cmp_match[i]); // R10
        AST_PWM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            wr_hit[i] && pwm_eff[i] && !go[i] |=> $stable(cnt[i])); // R6
    end
    for (genvar p = 0; p < NPAIR; p++) begin : g_pchk
        AST_UPPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            cascade[p] && $past(cascade[p]) |-> !cmp_match[2*p+1]); // R10
    end
endmodule

// File: tb/qcnt_unit_tb.sv
module qcnt_unit_tb_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [3:0] cnt_on = '0, cnt_dn = '0, pwm_mode = '0, pin_tick = '0;
    logic [7:0] ck_sel = '0, wr_data = '0;
    logic [1:0] cascade = '0, wr_sel = '0, rd_sel = '0;
    logic [5:0] int_tick = '0;
    logic       wr_en = 0;
    logic [7:0] rd_data;
    logic [3:0] cmp_match, pwm_out, wr_pending;
    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    qcnt_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_on(cnt_on), .ck_sel(ck_sel),
        .cnt_dn(cnt_dn), .pwm_mode(pwm_mode), .cascade(cascade),
        .int_tick(int_tick), .pin_tick(pin_tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .cmp_match(cmp_match), .pwm_out(pwm_out),
        .wr_pending(wr_pending)
    );

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(int i, output int v);
        rd_sel = 2'(i);
        #1 v = int'(rd_data);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; cnt_on = '0; cnt_dn = '0; pwm_mode = '0; ck_sel = '0; cascade = '0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic pulse_int(int b);
        @(negedge clk) int_tick[b] = 1'b1;
        @(negedge clk) int_tick[b] = 1'b0;
    endtask

    task automatic pulse_pin(int b);
        @(negedge clk) pin_tick[b] = 1'b1;
        @(negedge clk) pin_tick[b] = 1'b0;
    endtask

    task automatic wr(int i, int d);
        @(negedge clk) begin wr_en = 1; wr_sel = 2'(i); wr_data = 8'(d); end
        @(negedge clk) wr_en = 0;
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        for (int i = 0; i < 4; i++) begin
            rd(i, v);
            chk("R1 count", v, 0);
        end
        chk("R1 pending", int'(wr_pending), 0);
        chk("R1 match", int'(cmp_match), 0);
        chk("R1 pwm", int'(pwm_out), 0);
    endtask

    task automatic t_clksel();
        int v;
        cnt_on = 4'b0101;
        ck_sel = 8'b00_10_00_00;
        repeat (3) pulse_int(0);
        rd(0, v); chk("R2 int code0", v, 3);
        pulse_int(1);
        rd(0, v); chk("R2 other source ignored", v, 3);
        pulse_int(5);
        rd(2, v); chk("R2 upper group code2", v, 1);
        pulse_int(2);
        rd(2, v); chk("R2 lower group ignored by C", v, 1);
        rd(0, v); chk("R12 read A", v, 3);
        ck_sel[1:0] = 2'b11;
        pulse_pin(0);
        rd(0, v); chk("R2 pin code3", v, 4);
        pulse_pin(1);
        rd(0, v); chk("R2 foreign pin ignored", v, 4);
    endtask

    task automatic t_freeze();
        int v;
        cnt_on[0] = 0;
        repeat (2) pulse_pin(0);
        rd(0, v); chk("R3 stopped frozen", v, 4);
    endtask

    task automatic t_upwrite();
        int v;
        wr(0, 8'h10);
        rd(0, v); chk("R4 write defers", v, 4);
        chk("R4 pending set", int'(wr_pending[0]), 1);
        cnt_on[0] = 1;
        pulse_pin(0);
        rd(0, v); chk("R4 cleared on tick", v, 0);
        chk("R4 pending cleared", int'(wr_pending[0]), 0);
        for (int k = 1; k <= 16; k++) begin
            pulse_pin(0);
            if (k == 15) chk("R10 no early match", int'(cmp_match[0]), 0);
        end
        rd(0, v); chk("R4 counts after clear", v, 16);
        chk("R10 match pulse", int'(cmp_match[0]), 1);
        @(negedge clk);
        chk("R10 match one cycle", int'(cmp_match[0]), 0);
    endtask

    task automatic t_down();
        int v;
        ck_sel[3:2] = 2'b11; cnt_dn[1] = 1; cnt_on[1] = 1;
        wr(1, 2);
        chk("R5 pending set", int'(wr_pending[1]), 1);
        pulse_pin(1);
        rd(1, v); chk("R5 load compare", v, 2);
        chk("R10 no match on load", int'(cmp_match[1]), 0);
        repeat (3) pulse_pin(1);
        rd(1, v); chk("R8 down wrap", v, 8'hFF);
    endtask

    task automatic t_pwm();
        int v;
        pwm_mode[2] = 1;
        wr(2, 5);
        rd(2, v); chk("R6 count kept", v, 1);
        chk("R6 no pending", int'(wr_pending[2]), 0);
        chk("R11 below compare", int'(pwm_out[2]), 1);
        pulse_int(5);
        rd(2, v); chk("R11 pwm counts", v, 2);
        wr(2, 2);
        chk("R11 at compare low", int'(pwm_out[2]), 0);
        @(negedge clk) pwm_mode[2] = 0;
        @(negedge clk);
        rd(2, v); chk("R7 mode change keeps count", v, 2);
    endtask

    task automatic t_cascade();
        int v;
        do_reset();
        ck_sel = 8'b0000_1111; cascade = 2'b01; cnt_on = 4'b0001;
        wr(1, 1);
        chk("R13 upper write marks pair", int'(wr_pending[1:0]), 3);
        wr(0, 2);
        pulse_pin(0);
        chk("R13 pair pending cleared", int'(wr_pending[1:0]), 0);
        pulse_pin(1);
        rd(1, v); chk("R9 upper own tick ignored", v, 0);
        repeat (256) pulse_pin(0);
        rd(0, v); chk("R8 up wrap low byte", v, 0);
        rd(1, v); chk("R9 upper carries", v, 1);
        repeat (2) pulse_pin(0);
        chk("R10 16-bit match", int'(cmp_match[1:0]), 1);
        @(negedge clk) pwm_mode[0] = 1;
        #1 chk("R11 16-bit equal low", int'(pwm_out[1:0]), 0);
        wr(0, 3);
        chk("R6 pwm write no pending", int'(wr_pending[1:0]), 0);
        chk("R11 16-bit below", int'(pwm_out[1:0]), 1);
        cnt_on = '0;
        pulse_pin(0);
        rd(0, v); chk("R3 pair stopped", v, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_clksel();
        t_freeze();
        t_upwrite();
        t_down();
        t_pwm();
        t_cascade();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule